// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block is the combinational operand shifter in front of an integer ALU. It takes a data word and shifts or rotates it by one of five operations: logical left, logical right, arithmetic right, rotate right, and rotate right by one through the carry flag. It returns the shifted word and the carry-out that the shift produces. One select input says where the shift distance comes from. It is either a short field encoded in the instruction (the immediate form) or the low byte of a register (the register form). The two forms treat a zero distance differently.

A distance of zero in the immediate form stands for a full-word shift when the operation is a right shift, logical or arithmetic. For a left shift or a rotate, a zero immediate distance leaves the word as it is. In the register form, a zero distance always passes the word and the incoming carry through unchanged. Distances of a full word or more follow fixed saturation rules. A shift-kind code outside the five defined ones yields a zero word, a zero carry and an error flag.

The unit has no clock and no state. Its outputs settle from the current inputs in the same cycle. Decode, flag storage and the ALU that follows are outside the block.

Top module: `shop_unit`

## Requirements
- R1: Shift-kind code 0 selects logical left. For a distance n from 1 to 31, the result is the base shifted left by n with zeros filled in, and the carry-out is base bit (32−n).
- R2: Codes 1 (logical right), 2 (arithmetic right) and 3 (rotate right) cover distances n from 1 to 31. Code 1 fills with zeros. Code 2 fills with copies of base bit 31. Code 3 wraps the low bits round into the top. In all three the carry-out is base bit (n−1).
- R3: Code 4 (rotate through carry) puts carry_i into result bit 31 and base bits 31:1 into result bits 30:0. The carry-out is base bit 0. Both distance fields are ignored for this code.
- R4: In the immediate form (amt_from_reg_i = 0), an encoded distance of zero with code 1 or 2 acts as a shift by 32. Code 1 then gives a zero result and code 2 gives every bit equal to base bit 31. In both cases the carry-out is base bit 31.
- R5: In the immediate form, an encoded distance of zero with code 0 or 3 returns the base unchanged. The carry-out equals carry_i.
- R6: In the register form (amt_from_reg_i = 1), a register distance of zero with any of codes 0 to 3 returns the base unchanged. The carry-out equals carry_i.
- R7: In the register form, code 3 rotates by the low 5 bits of the register distance. A nonzero distance whose low 5 bits are zero returns the base unchanged, with base bit 31 as the carry-out.
- R8: In the register form, codes 0 and 1 with a distance of 32 or more give a zero result. At exactly 32 the carry-out is base bit 0 for code 0 and base bit 31 for code 1. Above 32 the carry-out is 0.
- R9: In the register form, code 2 with a distance of 32 or more gives every result bit equal to base bit 31. The carry-out is also base bit 31.
- R10: Codes 5, 6 and 7 give a zero result, a zero carry-out and kind_err_o = 1. Codes 0 to 4 give kind_err_o = 0.
- R11: The immediate form ignores reg_amt_i, and the register form ignores imm_amt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Operand word to be shifted |
| imm_amt_i | input | 5 | Shift distance encoded in the instruction |
| reg_amt_i | input | 8 | Shift distance taken from a register's low byte |
| kind_i | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amt_from_reg_i | input | 1 | 1 selects reg_amt_i, 0 selects imm_amt_i |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| kind_err_o | output | 1 | Shift-kind code is undefined |

## Verification
Two functions can give the same result word in one evaluation: the zero-distance pass-through and the full-turn rotate. The register form reaches both, with distance 0 and with distances 32, 64, 96 and so on. Only the carry-out tells them apart: carry_i for the pass-through, base bit 31 for the full turn. The sweep therefore covers every register distance from 0 to 255 for every kind and both form selects. It compares the result and the carry-out against arithmetic on 64-bit words, and it uses bases whose bit 31 differs from the carry-in being driven.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shop_kind_e;

    function automatic logic kind_defined(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/shop_amount.sv
module shop_amount
    import shop_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG2W = $clog2(WIDTH)
) (
    input  shop_kind_e       kind_i,
    input  logic             from_reg_i,
    input  logic [LOG2W-1:0] imm_amt_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    output logic [AMT_W-1:0] amt_o,
    output logic             pass_o
);

    localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

    always_comb begin
        pass_o = 1'b0;
        amt_o  = '0;
        if (kind_i == SH_RRX) begin
            amt_o = AMT_W'(1);
        end else if (from_reg_i) begin
            if (reg_amt_i == '0) begin
                pass_o = 1'b1;
            end else if (kind_i == SH_ROR) begin
                amt_o = (reg_amt_i[LOG2W-1:0] == '0) ? FULL
                                                     : AMT_W'(reg_amt_i[LOG2W-1:0]);
            end else begin
                amt_o = reg_amt_i;
            end
        end else begin
            if (imm_amt_i == '0) begin
                if (kind_i == SH_LSR || kind_i == SH_ASR) amt_o = FULL;
                else                                      pass_o = 1'b1;
            end else begin
                amt_o = AMT_W'(imm_amt_i);
            end
        end
    end

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
    import shop_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG2W = $clog2(WIDTH)
) (
    input  shop_kind_e       kind_i,
    input  logic [WIDTH-1:0] base_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             pass_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o
);

    logic [WIDTH-1:0] rot;
    int               n;
    int               m;

    always_comb begin
        n   = int'(amt_i);
        m   = int'(amt_i[LOG2W-1:0]);
        rot = base_i;
        for (int s = 0; s < LOG2W; s++) begin
            if (amt_i[s]) rot = (rot >> (1 << s)) | (rot << (WIDTH - (1 << s)));
        end

        if (pass_i && kind_i != SH_RRX) begin
            res_o = base_i;
        end else begin
            unique case (kind_i)
                SH_LSL:  res_o = (n >= WIDTH) ? '0 : (base_i << n);
                SH_LSR:  res_o = (n >= WIDTH) ? '0 : (base_i >> n);
                SH_ASR:  res_o = (n >= WIDTH) ? {WIDTH{base_i[WIDTH-1]}}
                                              : WIDTH'($signed(base_i) >>> n);
                SH_ROR:  res_o = rot;
                SH_RRX:  res_o = {cin_i, base_i[WIDTH-1:1]};
                default: res_o = '0;
            endcase
        end

        if (pass_i && kind_i inside {SH_LSL, SH_LSR, SH_ASR, SH_ROR})
            AST_PASS_RESULT: assert (res_o == base_i) else $error("pass-through altered word"); // R6
        if (kind_i == SH_ROR)
            AST_ROR_POPCOUNT: assert ($countones(res_o) == $countones(base_i)) else $error("rotate changed bit count"); // R2
        if (kind_i == SH_ROR && !pass_i && m != 0)
            AST_ROR_ROUNDTRIP: assert (((res_o << m) | (res_o >> (WIDTH - m))) == base_i) else $error("rotate not invertible"); // R7
        if (kind_i == SH_ASR && !pass_i)
            AST_ASR_SIGN: assert (res_o[WIDTH-1] == base_i[WIDTH-1]) else $error("arith shift lost sign"); // R9
    end

endmodule

// File: rtl/shop_carry.sv
module shop_carry
    import shop_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  shop_kind_e       kind_i,
    input  logic [WIDTH-1:0] base_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             pass_i,
    input  logic             cin_i,
    output logic             cout_o
);

    logic [WIDTH-1:0] probe;
    int               n;

    always_comb begin
        n     = int'(amt_i);
        probe = '0;
        if (kind_i == SH_RRX) begin
            cout_o = base_i[0];
        end else if (pass_i) begin
            cout_o = cin_i;
        end else begin
            unique case (kind_i)
                SH_LSL: begin
                    if (n >= 1 && n <= WIDTH) probe = base_i >> (WIDTH - n);
                    cout_o = probe[0];
                end
                SH_LSR, SH_ROR: begin
                    if (n >= 1 && n <= WIDTH) probe = base_i >> (n - 1);
                    cout_o = probe[0];
                end
                SH_ASR: begin
                    if (n >= WIDTH) probe = {WIDTH{base_i[WIDTH-1]}};
                    else if (n >= 1) probe = base_i >> (n - 1);
                    cout_o = probe[0];
                end
                default: cout_o = 1'b0;
            endcase
        end

        if (pass_i && kind_i inside {SH_LSL, SH_LSR, SH_ASR, SH_ROR})
            AST_PASS_CARRY: assert (cout_o == cin_i) else $error("pass-through carry wrong"); // R6
        if (kind_i == SH_LSL && !pass_i && n > WIDTH)
            AST_BIG_LSL_CARRY: assert (cout_o == 1'b0) else $error("oversized left shift carry"); // R8
        if (kind_i == SH_RRX)
            AST_RRX_CARRY: assert (cout_o == base_i[0]) else $error("rotate-through-carry carry wrong"); // R3
    end

endmodule

// File: rtl/shop_unit.sv
module shop_unit
    import shop_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG2W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] base_i,
    input  logic [LOG2W-1:0] imm_amt_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    input  logic [2:0]       kind_i,
    input  logic             amt_from_reg_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             kind_err_o
);

    shop_kind_e       kind;
    logic [AMT_W-1:0] eff_amt;
    logic             pass;
    logic [WIDTH-1:0] shifted;
    logic             shift_cout;
    logic             bad_kind;

    assign kind     = shop_kind_e'(kind_i);
    assign bad_kind = !kind_defined(kind_i);

    shop_amount #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amount (
        .kind_i     (kind),
        .from_reg_i (amt_from_reg_i),
        .imm_amt_i  (imm_amt_i),
        .reg_amt_i  (reg_amt_i),
        .amt_o      (eff_amt),
        .pass_o     (pass)
    );

    shop_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
        .kind_i (kind),
        .base_i (base_i),
        .amt_i  (eff_amt),
        .pass_i (pass),
        .cin_i  (carry_i),
        .res_o  (shifted)
    );

    shop_carry #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_carry (
        .kind_i (kind),
        .base_i (base_i),
        .amt_i  (eff_amt),
        .pass_i (pass),
        .cin_i  (carry_i),
        .cout_o (shift_cout)
    );

    always_comb begin
        kind_err_o = bad_kind;
        result_o   = bad_kind ? '0   : shifted;
        carry_o    = bad_kind ? 1'b0 : shift_cout;
    end

endmodule

// File: tb/shop_unit_bench.sv
module shop_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [31:0] base;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic [2:0]  kind;
    logic        from_reg;
    logic        cin;
    logic [31:0] result;
    logic        cout;
    logic        kerr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    shop_unit u_shop_unit (
        .base_i         (base),
        .imm_amt_i      (imm_amt),
        .reg_amt_i      (reg_amt),
        .kind_i         (kind),
        .amt_from_reg_i (from_reg),
        .carry_i        (cin),
        .result_o       (result),
        .carry_o        (cout),
        .kind_err_o     (kerr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Returns {err, carry, result}
    function automatic logic [33:0] model(input logic [31:0] b, input int k, input bit fr,
                                          input int ia, input int ra, input logic c);
        logic [63:0]        w;
        logic signed [63:0] sw;
        logic [31:0]        r;
        logic               co;
        int                 n;
        bit                 pass;
        if (k > 4) return {1'b1, 1'b0, 32'h0};
        if (k == 4) return {1'b0, b[0], c, b[31:1]};
        pass = 0;
        n    = 0;
        if (fr) begin
            if (ra == 0) pass = 1;
            else if (k == 3) n = (ra % 32 == 0) ? 32 : ra % 32;
            else n = ra;
        end else begin
            if (ia == 0) begin
                if (k == 1 || k == 2) n = 32; else pass = 1;
            end else n = ia;
        end
        if (pass) return {1'b0, c, b};
        case (k)
            0: begin
                w  = (n < 64) ? ({32'h0, b} << n) : 64'h0;
                r  = w[31:0];
                co = (n <= 32) ? w[32] : 1'b0;
            end
            1: begin
                w  = (n < 64) ? ({b, 32'h0} >> n) : 64'h0;
                r  = w[63:32];
                co = w[31];
            end
            2: begin
                sw = $signed({b, 32'h0});
                sw = sw >>> ((n > 40) ? 40 : n);
                r  = sw[63:32];
                co = sw[31];
            end
            default: begin
                w  = {b, b} >> (n % 32);
                r  = w[31:0];
                co = r[31];
            end
        endcase
        return {1'b0, co, r};
    endfunction

    function automatic string tag(input int k, input bit fr, input int ia, input int ra);
        if (k > 4)  return "R10";
        if (k == 4) return "R3";
        if (fr) begin
            if (ra == 0) return "R6";
            if (k == 3 && ra >= 32) return "R7";
            if ((k == 0 || k == 1) && ra >= 32) return "R8";
            if (k == 2 && ra >= 32) return "R9";
        end else begin
            if (ia == 0 && (k == 1 || k == 2)) return "R4";
            if (ia == 0) return "R5";
        end
        if (k == 0) return "R1";
        return "R2";
    endfunction

    task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s kind=%0d reg=%0b imm=%0d ramt=%0d base=%h: actual %h expected %h",
                     t, what, kind, from_reg, imm_amt, reg_amt, base, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] b, input int k, input bit fr, input int ia,
                         input int ra, input logic c);
        logic [33:0] e;
        string       t;
        base     = b;
        kind     = 3'(k);
        from_reg = fr;
        imm_amt  = 5'(ia);
        reg_amt  = 8'(ra);
        cin      = c;
        #2;
        e = model(b, k, fr, ia, ra, c);
        t = tag(k, fr, ia, ra);
        check(t, "result", result, e[31:0]);
        check(t, "carry", {31'h0, cout}, {31'h0, e[32]});
        check("R10", "err", {31'h0, kerr}, {31'h0, e[33]});
    endtask

    logic [31:0] bases [5] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_1E69, 32'h0000_0000, 32'hFFFF_FFFF};

    initial begin
        base = '0; imm_amt = '0; reg_amt = '0; kind = '0; from_reg = 1'b0; cin = 1'b0;
        @(negedge clk);
        // idle inputs: kind 0, immediate zero -> pass-through of zero (R5)
        check("R5", "idle result", result, 32'h0);
        check("R10", "idle err", {31'h0, kerr}, 32'h0);
        for (int bi = 0; bi < 5; bi++) begin
            for (int k = 0; k < 8; k++) begin
                // Immediate form; reg field holds a distracting value (R11)
                for (int ia = 0; ia < 32; ia++) begin
                    apply(bases[bi], k, 1'b0, ia, (ia * 37 + 5) % 256, 1'((ia + bi) % 2));
                end
                // Register form; imm field holds a distracting value (R11)
                for (int ra = 0; ra < 256; ra++) begin
                    apply(bases[bi], k, 1'b1, (ra * 7 + 3) % 32, ra, 1'(~bases[bi][31] ^ ra[0]));
                end
            end
        end
        // R11: same register distance, differing immediate field -> same output
        apply(32'h1234_5678, 0, 1'b1, 0, 4, 1'b0);
        apply(32'h1234_5678, 0, 1'b1, 31, 4, 1'b0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule